// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between an internal request port and an external 32K x 8 asynchronous static RAM. A client presents an address, a write flag and a write byte with a valid/ready handshake. The controller takes one request at a time. It turns each request into a strobe sequence on the memory pins, and every phase of that sequence lasts a whole number of system clock ticks. The tick counts are derived at elaboration from nanosecond minimums and the clock period, each rounded up.

The write is terminated by the write strobe. The controller drives the data byte one tick before the write strobe falls and keeps it on the bus while the strobe is low. It stops driving on the tick the strobe rises. The output-enable strobe stays high for the whole write. A read holds chip enable and output enable low for the access time, samples the byte on the closing edge and returns it with a one-clock valid strobe. After every read, all strobes go high and the bus is left undriven for a release period, so the memory can let go of the bus before anything else drives it. Chip enable is high whenever no transfer is in progress.

States: IDLE (waiting, ready high), W_LEAD (data driven, write strobe still high), W_PULSE (write strobe low), W_RECOV (write strobe high, bus released, chip still selected), R_ACCESS (chip and output enable low), R_RELEASE (all strobes high, bus floating). Transitions:
- IDLE to W_LEAD when a write is accepted.
- IDLE to R_ACCESS when a read is accepted.
- W_LEAD to W_PULSE after one tick.
- W_PULSE to W_RECOV and R_ACCESS to R_RELEASE when their tick counters expire.
- W_RECOV and R_RELEASE back to IDLE when their tick counters expire.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is low and right after it is released, sram_ce_n, sram_we_n and sram_oe_n are 1, sram_dq_oe and rd_valid are 0, and req_ready is 1.
- R2: req_ready is 1 only while no transfer is in progress, and sram_ce_n is then 1. A request held valid while the controller is busy is not taken, and its address is left untouched.
- R3: During a write, sram_dq_oe is 1 with sram_we_n still 1 for exactly one tick before sram_we_n falls.
- R4: sram_we_n stays low for WE_LOW_CYC = max(ceil(tWP/T), ceil(tDS/T)) ticks, which is 2 at the defaults. sram_ce_n is 0 and sram_oe_n is 1 throughout that time.
- R5: sram_dq_oe is 1 only in the lead tick and the write-strobe-low ticks. It is 0 from the tick sram_we_n rises.
- R6: sram_addr holds the accepted address, unchanged, for the whole time sram_ce_n is low in one transfer.
- R7: A write keeps sram_ce_n low for 1 + WE_LOW_CYC + REC_CYC ticks, which is 4 at the defaults. REC_CYC is at least 1 and makes the total at least ceil(tWC/T).
- R8: A read holds sram_ce_n and sram_oe_n low, sram_we_n high and sram_dq_oe 0 for RD_CYC = max(ceil(tAA/T), ceil(tOE/T)) ticks, which is 2 at the defaults. The byte on sram_dq_in is sampled on the edge that ends that period.
- R9: Each read produces exactly one rd_valid pulse of one clock, carrying the sampled byte. A write produces none.
- R10: After a read, every strobe is 1 and sram_dq_oe is 0 for REL_CYC = ceil(tRelease/T) ticks (1 at the defaults) before req_ready returns, so controller drive never overlaps the memory's late release.
- R11: A read of an address returns the byte most recently written there, including for a write issued right after a read and for repeated writes to one address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-clock strobe, rd_data holds a read byte |
| rd_data | output | 8 | Byte returned by the last read |
| sram_addr | output | 15 | Memory address pins |
| sram_dq_out | output | 8 | Byte the controller puts on the data bus |
| sram_dq_in | input | 8 | Byte seen on the data bus |
| sram_dq_oe | output | 1 | 1 = controller drives the data bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |

## Verification
The hardest case to reach from the ports is a write that follows a read as closely as the handshake allows. This is the only point where the controller's drive could overlap the memory's late release of the bus. The bench issues a write to an address in the first ready cycle after a read of that same address. Its memory model keeps the read drive alive for one tick after output enable rises, and it flags any controller drive in that window. It also holds a request valid with different fields while a write is in progress and then reads that address back, to show the held request was never taken.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W_LEAD,
        ST_W_PULSE,
        ST_W_RECOV,
        ST_R_ACCESS,
        ST_R_RELEASE
    } ctrl_state_t;

    // Convert a minimum time in picoseconds to whole clock ticks, rounding up, never below one.
    function automatic int unsigned ps_to_ticks(input int unsigned ps, input int unsigned clk_ps);
        int unsigned t;
        t = (ps + clk_ps - 1) / clk_ps;
        return (t == 0) ? 1 : t;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_tick_timer.sv
module sram_tick_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W      = 2,
    parameter int unsigned WE_LOW_CYC = 2,
    parameter int unsigned RD_CYC     = 2,
    parameter int unsigned REL_CYC    = 1,
    parameter int unsigned REC_CYC    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             accept,
    output logic             rd_capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             req_ready,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);

    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(WE_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] READ_LD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] REL_LD   = CNT_W'(REL_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD   = CNT_W'(REC_CYC - 1);

    ctrl_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and per-transition controls
    always_comb begin
        state_d    = state_q;
        accept     = 1'b0;
        rd_capture = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        state_d = ST_W_LEAD;
                    end else begin
                        state_d  = ST_R_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = READ_LD;
                    end
                end
            end
            ST_W_LEAD: begin
                state_d  = ST_W_PULSE;
                tmr_load = 1'b1;
                tmr_val  = PULSE_LD;
            end
            ST_W_PULSE: begin
                if (tmr_done) begin
                    state_d  = ST_W_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = REC_LD;
                end
            end
            ST_W_RECOV: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_R_ACCESS: begin
                if (tmr_done) begin
                    state_d    = ST_R_RELEASE;
                    rd_capture = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = REL_LD;
                end
            end
            ST_R_RELEASE: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Pin strobes decoded from the state register
    always_comb begin
        req_ready = 1'b0;
        ce_n      = 1'b1;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        dq_oe     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_W_LEAD: begin
                ce_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_W_PULSE: begin
                ce_n  = 1'b0;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_W_RECOV: begin
                ce_n = 1'b0;
            end
            ST_R_ACCESS: begin
                ce_n = 1'b0;
                oe_n = 1'b0;
            end
            ST_R_RELEASE: begin
                ce_n = 1'b1;
            end
            default: begin
                ce_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rd_capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // Request hold registers: stable for the whole transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Read capture on the edge that closes the access window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_capture;
            if (rd_capture) begin
                rd_data <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 15,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned T_WC_PS       = 20000,
    parameter int unsigned T_WP_PS       = 15000,
    parameter int unsigned T_DS_PS       = 10000,
    parameter int unsigned T_AA_PS       = 20000,
    parameter int unsigned T_OE_PS       = 9000,
    parameter int unsigned T_REL_PS      = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);

    localparam int unsigned WE_LOW_CYC = umax(ps_to_ticks(T_WP_PS, CLK_PERIOD_PS),
                                              ps_to_ticks(T_DS_PS, CLK_PERIOD_PS));
    localparam int unsigned WC_CYC     = ps_to_ticks(T_WC_PS, CLK_PERIOD_PS);
    localparam int unsigned REC_CYC    = (WC_CYC > WE_LOW_CYC + 2) ? (WC_CYC - WE_LOW_CYC - 1) : 1;
    localparam int unsigned RD_CYC     = umax(ps_to_ticks(T_AA_PS, CLK_PERIOD_PS),
                                              ps_to_ticks(T_OE_PS, CLK_PERIOD_PS));
    localparam int unsigned REL_CYC    = ps_to_ticks(T_REL_PS, CLK_PERIOD_PS);
    localparam int unsigned MAX_CYC    = umax(umax(WE_LOW_CYC, REC_CYC), umax(RD_CYC, REL_CYC));
    localparam int unsigned CNT_W      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic             accept;
    logic             rd_capture;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;

    sram_tick_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctrl_fsm #(
        .CNT_W      (CNT_W),
        .WE_LOW_CYC (WE_LOW_CYC),
        .RD_CYC     (RD_CYC),
        .REL_CYC    (REL_CYC),
        .REC_CYC    (REC_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .tmr_done   (tmr_done),
        .accept     (accept),
        .rd_capture (rd_capture),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .req_ready  (req_ready),
        .ce_n       (sram_ce_n),
        .oe_n       (sram_oe_n),
        .we_n       (sram_we_n),
        .dq_oe      (sram_dq_oe)
    );

    sram_ctrl_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_capture (rd_capture),
        .dq_in      (sram_dq_in),
        .addr_q     (sram_addr),
        .wdata_q    (sram_dq_out),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int unsigned ADDR_W     = 15,
    parameter int unsigned WE_LOW_CYC = 2,
    parameter int unsigned RD_CYC     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_dq_oe,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n
);

    int unsigned we_lo_cnt;
    int unsigned oe_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= 0;
            oe_lo_cnt <= 0;
        end else begin
            we_lo_cnt <= sram_we_n ? 0 : we_lo_cnt + 1;
            oe_lo_cnt <= sram_oe_n ? 0 : oe_lo_cnt + 1;
        end
    end

    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

    p_lead_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> ($past(sram_dq_oe) && !$past(sram_ce_n)));

    p_we_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n));

    p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_lo_cnt >= WE_LOW_CYC));

    p_drive_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (!sram_ce_n && sram_oe_n));

    p_release_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> !sram_dq_oe);

    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    p_read_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_dq_oe && sram_we_n && !sram_ce_n));

    p_read_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (oe_lo_cnt == RD_CYC));

    p_rdvalid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_turnaround_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (sram_ce_n && !sram_dq_oe && !req_ready));

endmodule

bind sram_ctrl sram_ctrl_checker #(
    .ADDR_W     (ADDR_W),
    .WE_LOW_CYC (WE_LOW_CYC),
    .RD_CYC     (RD_CYC)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .sram_addr  (sram_addr),
    .sram_dq_oe (sram_dq_oe),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

    localparam int WE_LOW_EXP = 2;   // R4 at defaults
    localparam int WR_CE_EXP  = 4;   // R7 at defaults
    localparam int RD_EXP     = 2;   // R8 at defaults

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [14:0] sram_addr;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in = 8'h00;
    logic        sram_dq_oe;
    logic        sram_ce_n, sram_oe_n, sram_we_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sram_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
        .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] init_byte(input int a);
        return 8'(a ^ (a >> 7)) ^ 8'h3C;
    endfunction

    // ---------------- memory model (samples at negedge) ----------------
    logic [7:0] mem [int];
    logic [7:0] shadow [int];

    function automatic logic [7:0] mem_rd(input int a);
        return mem.exists(a) ? mem[a] : init_byte(a);
    endfunction

    bit         p_we_n = 1, p_ce_n = 1, p_dq_oe = 0, p_rd = 0;
    int         wlow = 0, rcnt = 0, celow = 0;
    bit         was_write = 0;
    logic [14:0] w_addr, r_addr;
    logic [7:0]  w_data;

    always @(negedge clk) begin
        if (rst_n) begin
            bit rd_act;
            // write strobe tracking
            if (!sram_we_n) begin
                if (p_we_n) begin
                    chk(p_dq_oe && sram_dq_oe, "R3 lead drive", int'(p_dq_oe), 1);
                    w_addr = sram_addr;
                    wlow   = 0;
                end
                wlow++;
                was_write = 1;
                if (!(!sram_ce_n && sram_oe_n && sram_dq_oe))
                    chk(0, "R4 strobes during write", {sram_ce_n, sram_oe_n, sram_dq_oe}, 3'b011);
                if (sram_addr != w_addr) chk(0, "R6 write address", sram_addr, w_addr);
                w_data = sram_dq_out;
            end else if (!p_we_n) begin
                chk(wlow == WE_LOW_EXP, "R4 write strobe width", wlow, WE_LOW_EXP);
                chk(!sram_dq_oe, "R5 drive released at strobe rise", sram_dq_oe, 0);
                mem[int'(w_addr)] = w_data;
            end
            // read tracking
            rd_act = !sram_ce_n && !sram_oe_n && sram_we_n;
            if (rd_act) begin
                rcnt++;
                if (rcnt == 1) r_addr = sram_addr;
                else if (sram_addr != r_addr) chk(0, "R6 read address", sram_addr, r_addr);
                if (sram_dq_oe) chk(0, "R8 drive during read", 1, 0);
            end else if (p_rd) begin
                chk(rcnt == RD_EXP, "R8 read window", rcnt, RD_EXP);
                rcnt = 0;
            end
            // bus overlap with memory drive and its release tail
            if (sram_dq_oe && (rd_act || p_rd)) chk(0, "R10 bus overlap", 1, 0);
            // chip-select length for writes
            if (!sram_ce_n) celow++;
            else if (!p_ce_n) begin
                if (was_write) chk(celow == WR_CE_EXP, "R7 write cycle length", celow, WR_CE_EXP);
                celow = 0;
                was_write = 0;
            end
            // memory drives valid data only after the access window has elapsed
            if (rd_act) sram_dq_in = (rcnt >= RD_EXP) ? mem_rd(int'(r_addr)) : ~mem_rd(int'(r_addr));
            else        sram_dq_in = 8'hEE;
            p_we_n  = sram_we_n;
            p_ce_n  = sram_ce_n;
            p_dq_oe = sram_dq_oe;
            p_rd    = rd_act;
        end
    end

    // ---------------- scoreboard monitor ----------------
    logic [7:0] exp_q [$];
    bit prev_rdv = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                chk(!prev_rdv, "R9 one-clock pulse", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected rd_valid", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R11 read data", rd_data, e);
                end
            end
            prev_rdv = rd_valid;
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d, input int hold_junk);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        if (wr) shadow[int'(a)] = d;
        else    exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : init_byte(int'(a)));
        @(negedge clk);
        chk(!req_ready, "R2 busy after accept", req_ready, 0);
        if (hold_junk > 0) begin
            req_write = 1'b1;
            req_addr  = 15'h0200;
            req_wdata = 8'hBD;
            for (int i = 0; i < hold_junk; i++) begin
                chk(!req_ready, "R2 ready while busy", req_ready, 0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        req_addr  = 15'h7A5A;
        req_wdata = 8'h66;
    endtask

    initial begin
        logic [14:0] lfsr;
        repeat (3) @(negedge clk);
        chk(sram_ce_n == 1, "R1 ce_n in reset", sram_ce_n, 1);
        chk(sram_we_n == 1 && sram_oe_n == 1, "R1 we_n/oe_n in reset", {sram_we_n, sram_oe_n}, 3);
        chk(sram_dq_oe == 0 && rd_valid == 0, "R1 dq_oe/rd_valid in reset", {sram_dq_oe, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
        chk(sram_ce_n == 1, "R2 ce_n idle", sram_ce_n, 1);

        issue(1, 15'h0000, 8'h5A, 0);
        issue(1, 15'h7FFF, 8'hA5, 0);
        issue(0, 15'h0000, 8'h00, 0);
        issue(0, 15'h7FFF, 8'h00, 0);
        issue(0, 15'h1234, 8'h00, 0);
        // write right after read of the same address (R10, R11)
        issue(0, 15'h0010, 8'h00, 0);
        issue(1, 15'h0010, 8'hC3, 0);
        issue(0, 15'h0010, 8'h00, 0);
        // request held valid with other fields while busy (R2)
        issue(1, 15'h0100, 8'h11, 2);
        issue(0, 15'h0200, 8'h00, 0);
        issue(0, 15'h0100, 8'h00, 0);
        // repeated writes to one address (R11)
        issue(1, 15'h0005, 8'h01, 0);
        issue(1, 15'h0005, 8'h02, 0);
        issue(0, 15'h0005, 8'h00, 0);
        // mixed traffic in a small window
        lfsr = 15'h1ACE;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
            issue(lfsr[0], {11'h3C0, lfsr[4:1]}, lfsr[12:5], 0);
        end
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
        chk(sram_ce_n == 1 && req_ready == 1, "R2 idle at end", {sram_ce_n, req_ready}, 3);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule